// File: doc/BRIEF.md
# RMII Transmit Dibit-to-Nibble Adapter

This block sits on the PHY side of a reduced media independent interface. A MAC presents a transmit enable and a 2-bit transmit data value on every rising edge of the 50 MHz reference clock. The block turns that stream back into 4-bit internal MII nibbles. Each nibble comes with a one-clock valid strobe and an internal transmit enable. The internal nibble timing is derived directly from the reference clock, so there is no elasticity buffer on this path.

A static speed input selects one of two modes. In 100 Mbit/s mode every reference clock carries a new dibit. In 10 Mbit/s mode each dibit is held for ten clocks. The block then takes exactly one sample per ten-clock group, at a fixed point counted from the rising edge of the transmit enable, so the frame may begin at any clock. Line coding, scrambling, the analog driver and collision handling belong to other blocks.

Top module: `rmii_tx_adapter`

## Requirements
- R1: A synchronous active-high reset clears the nibble output to 0, the valid strobe to 0, the internal transmit enable to 0, the partial-nibble state and the group counter.
- R2: In 100 Mbit/s mode (`speed_10` = 0) one dibit is taken on every clock edge where `rmii_tx_en` is 1. The first dibit of a pair becomes nibble bits [1:0] and the second becomes bits [3:2]. The nibble appears on `mii_txd` one clock after the edge that sampled its second dibit.
- R3: `mii_tx_valid` is a single-clock pulse, issued once for every two dibits taken. `mii_txd` holds its last value between pulses.
- R4: In 10 Mbit/s mode (`speed_10` = 1) exactly one dibit is taken per ten-clock group, at count 5 of that group. The dibit values on the other nine clocks of the group have no effect on the output.
- R5: In 10 Mbit/s mode the group count restarts at 0 on the clock where `rmii_tx_en` is first seen high. The count of 0 falls on that clock, so sample timing depends only on where the frame starts.
- R6: `mii_tx_en` rises together with the first valid nibble of a frame. It falls on the clock after an edge that samples `rmii_tx_en` low.
- R7: If `rmii_tx_en` falls while half a nibble is held, that dibit is discarded and the next frame starts again with bits [1:0].
- R8: While `rmii_tx_en` is 0, the value on `rmii_txd` (nominally 00 = idle) produces no valid strobe and does not enter any later nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| speed_10 | input | 1 | Static mode select: 1 = 10 Mbit/s, 0 = 100 Mbit/s |
| rmii_tx_en | input | 1 | Transmit enable from the MAC |
| rmii_txd | input | 2 | Transmit dibit from the MAC |
| mii_txd | output | 4 | Reassembled transmit nibble |
| mii_tx_valid | output | 1 | One-clock strobe marking a new nibble |
| mii_tx_en | output | 1 | Internal transmit enable |

## Verification
Four properties are checked on every clock. The valid strobe never lasts two clocks. A 10 Mbit/s sample is never followed by another on the next clock. A valid nibble always carries the internal enable. A low transmit enable is always followed by no strobe and a low internal enable. The remaining behaviours can only be shown by the bench's scenarios: nibble bit order, placement of the sample at count 5 after an arbitrary start, immunity to garbage on the nine unsampled clocks, discard of a half nibble, and recovery after a reset in mid-frame.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  localparam int DIBIT_W  = 2;
  localparam int NIBBLE_W = 4;
  localparam int DIBITS_PER_NIBBLE = NIBBLE_W / DIBIT_W;

  typedef logic [DIBIT_W-1:0]  dibit_t;
  typedef logic [NIBBLE_W-1:0] nibble_t;
endpackage

// File: rtl/rmii_tx_sampler.sv
module rmii_tx_sampler #(
  parameter int GROUP_LEN  = 10,
  parameter int SAMPLE_POS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic speed_10,
  input  logic tx_en,
  output logic take_o
);
  localparam int CNT_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GROUP_LEN - 1);
  localparam logic [CNT_W-1:0] SPOS     = CNT_W'(SAMPLE_POS);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] phase;

  // The group position restarts on the first clock of a frame.
  always_comb begin
    phase = (tx_en && !en_q) ? '0 : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= tx_en;
      if (!tx_en)
        cnt_q <= '0;
      else if (phase == LAST_CNT)
        cnt_q <= '0;
      else
        cnt_q <= phase + 1'b1;
    end
  end

  always_comb begin
    take_o = tx_en && (speed_10 ? (phase == SPOS) : 1'b1);
  end

  // R4
  sample_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (speed_10 && take_o) |=> !take_o);
endmodule

// File: rtl/rmii_tx_packer.sv
module rmii_tx_packer
  import rmii_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    take,
  input  logic    tx_en,
  input  dibit_t  dibit,
  output nibble_t nib_o,
  output logic    valid_o,
  output logic    en_o
);
  logic   half_q;
  dibit_t low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      low_q   <= '0;
      nib_o   <= '0;
      valid_o <= 1'b0;
      en_o    <= 1'b0;
    end else if (!tx_en) begin
      half_q  <= 1'b0;
      valid_o <= 1'b0;
      en_o    <= 1'b0;
    end else if (take) begin
      if (!half_q) begin
        low_q   <= dibit;
        half_q  <= 1'b1;
        valid_o <= 1'b0;
      end else begin
        nib_o   <= {dibit, low_q};
        half_q  <= 1'b0;
        valid_o <= 1'b1;
        en_o    <= 1'b1;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R6
  valid_en_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> en_o);
  // R6
  txen_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !en_o);
  // R8
  idle_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !valid_o);
endmodule

// File: rtl/rmii_tx_adapter.sv
module rmii_tx_adapter #(
  parameter int GROUP_LEN  = 10,
  parameter int SAMPLE_POS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speed_10,
  input  logic       rmii_tx_en,
  input  logic [1:0] rmii_txd,
  output logic [3:0] mii_txd,
  output logic       mii_tx_valid,
  output logic       mii_tx_en
);
  logic take;

  rmii_tx_sampler #(
    .GROUP_LEN (GROUP_LEN),
    .SAMPLE_POS(SAMPLE_POS)
  ) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .speed_10(speed_10),
    .tx_en   (rmii_tx_en),
    .take_o  (take)
  );

  rmii_tx_packer u_packer (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .tx_en  (rmii_tx_en),
    .dibit  (rmii_txd),
    .nib_o  (mii_txd),
    .valid_o(mii_tx_valid),
    .en_o   (mii_tx_en)
  );
endmodule

// File: tb/rmii_tx_adapter_tb.sv
module rmii_tx_adapter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_10 = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] txd = 2'b00;
  logic [3:0] mii_txd;
  logic       mii_tx_valid;
  logic       mii_tx_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rmii_tx_adapter u_dut (
    .clk(clk), .rst(rst), .speed_10(speed_10),
    .rmii_tx_en(tx_en), .rmii_txd(txd),
    .mii_txd(mii_txd), .mii_tx_valid(mii_tx_valid), .mii_tx_en(mii_tx_en)
  );

  // {speed_10, garble, dibit count, data}
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd8, 16'hA5C3},
    {1'b0, 1'b0, 4'd8, 16'hFFFF},
    {1'b0, 1'b0, 4'd3, 16'h002D},
    {1'b0, 1'b0, 4'd8, 16'h1E87},
    {1'b1, 1'b0, 4'd8, 16'h3C96},
    {1'b1, 1'b1, 4'd4, 16'h00B4},
    {1'b1, 1'b0, 4'd5, 16'h0279},
    {1'b1, 1'b0, 4'd4, 16'h0061}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [1:0] d);
    @(negedge clk);
    tx_en = en;
    txd   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input logic spd, input logic garble, input int ndib,
                           input logic [15:0] data);
    int  rep;
    bit  exp_en;
    rep    = spd ? 10 : 1;
    exp_en = 0;
    speed_10 = spd;
    for (int c = 0; c < ndib * rep; c++) begin
      int i;
      logic [1:0] dib;
      bit exp_v;
      i   = c / rep;
      dib = data[2*i +: 2];
      if (garble && spd && (c % 10 != 5)) dib = ~dib;
      step(1'b1, dib);
      exp_v = (spd ? (c % 10 == 5) : 1'b1) && (i % 2 == 1);
      // R3 R4 R5: strobe only at the expected sample clocks
      chk(mii_tx_valid == exp_v, spd ? "R4/R5 valid" : "R2/R3 valid", mii_tx_valid, exp_v);
      if (exp_v) begin
        logic [3:0] en_nib;
        en_nib = data[4*(i/2) +: 4];
        chk(mii_txd == en_nib, spd ? "R4 nibble" : "R2 nibble", mii_txd, en_nib);
        exp_en = 1;
      end
      // R6
      chk(mii_tx_en == exp_en, "R6 tx_en", mii_tx_en, exp_en);
    end
    step(1'b0, 2'b00);
    // R6 R7
    chk(mii_tx_en == 1'b0, "R6 fall", mii_tx_en, 0);
    chk(mii_tx_valid == 1'b0, "R7 no partial", mii_tx_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1'b0, 2'b00);
    step(1'b0, 2'b00);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    // R1
    chk(mii_txd == 4'h0, "R1 txd", mii_txd, 0);
    chk(mii_tx_valid == 1'b0, "R1 valid", mii_tx_valid, 0);
    chk(mii_tx_en == 1'b0, "R1 en", mii_tx_en, 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][21], VEC[v][20], int'(VEC[v][19:16]), VEC[v][15:0]);
      // R8: non-idle data while enable is low is ignored; gap length shifts frame start (R5)
      for (int g = 0; g < v + 2; g++) begin
        step(1'b0, 2'b11);
        chk(mii_tx_valid == 1'b0, "R8 idle", mii_tx_valid, 0);
      end
    end

    // R1: reset in mid-frame
    speed_10 = 1'b0;
    step(1'b1, 2'b10);
    step(1'b1, 2'b01);
    step(1'b1, 2'b11);
    chk(mii_txd == 4'h6, "R2 pre-reset nibble", mii_txd, 6);
    @(negedge clk) begin rst = 1'b1; tx_en = 1'b0; end
    @(posedge clk); #1;
    chk(mii_txd == 4'h0, "R1 mid txd", mii_txd, 0);
    chk(mii_tx_en == 1'b0, "R1 mid en", mii_tx_en, 0);
    @(negedge clk) rst = 1'b0;
    // R7: pending dibit cleared by reset, fresh frame aligns to bits [1:0]
    run_frame(1'b0, 1'b0, 4, 16'h00E4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule